// File: doc/BRIEF.md
# I2C Master Clock Phase Generator

This block produces the serial clock of an I2C master as an open-drain pull-down request. The low phase and the high phase each have their own 9-bit length in peripheral clock cycles. Each length is built from an 8-bit count register plus a separate ninth bit that sits in another register. For an even 5:4 low-to-high split at a bus rate F, software programs the low count as round(Fclk·5/(9·F)) and the high count as round(Fclk·4/(9·F)). The usual bus rates are 100 kHz, which is the default, and 400 kHz.

The byte engine uses three single-cycle strobes. One marks the start of each low phase. One marks the cycle after that, when SDA may change. One marks the middle of the high phase, when SDA is sampled. The high count starts only once the clock line is actually seen high, so a slave that stretches the clock delays it. A hold input from the byte engine keeps the clock low for as long as it is asserted.

The block registers the wire levels of both lines as status bits. It also gates the byte engine's SDA pull-down request with the module enable. Clearing the enable returns the generator to idle and releases both lines.

Top module: `scl_timing_gen`

## Requirements
- R1: In reset, and while enable is low, sclDriveLow, lowStart, sdaChange and samplePulse are all 0.
- R2: The low length is {lowExt, lowCount}; a value of 0 counts as 1. With holdLow low, sclDriveLow stays 1 for exactly that many cycles in each low phase.
- R3: The high length is {highExt, highCount}; a value of 0 counts as 1. When the line rises at once, the clock is released for exactly 1 + high length cycles: one sensing cycle, then the high count.
- R4: lowStart pulses for one cycle in the first cycle of every low phase, including the first one after enable rises.
- R5: sdaChange pulses for one cycle, in the cycle right after each lowStart.
- R6: samplePulse pulses exactly once per high phase, in high-count cycle number H + 1 − ceil(H/2), where H is the effective high length.
- R7: While the clock is released but sclIn reads low (a slave stretching the clock), the high count does not start. sclDriveLow stays 0 and no samplePulse occurs.
- R8: While holdLow is 1, the low phase does not end. It ends one cycle after holdLow falls, once its count has expired.
- R9: When enable falls, sclDriveLow is 0 from the next cycle on and no strobes occur. When enable rises again, a fresh low phase begins with lowStart on the next cycle.
- R10: sclLevel and sdaLevel show the sclIn and sdaIn levels one cycle later.
- R11: sdaDriveLow equals sdaReqLow while enable is 1, and is 0 while enable is 0.
- R12: A phase length is captured when its phase starts. Changing the count registers during a phase affects only later phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Module enable; low resets the generator and releases the lines |
| lowCount | input | 8 | Low-phase count, bits 7:0 |
| lowExt | input | 1 | Low-phase count, bit 8 |
| highCount | input | 8 | High-phase count, bits 7:0 |
| highExt | input | 1 | High-phase count, bit 8 |
| holdLow | input | 1 | Byte-engine request to keep SCL low |
| sdaReqLow | input | 1 | Byte-engine request to pull SDA low |
| sclIn | input | 1 | Sensed SCL wire level |
| sdaIn | input | 1 | Sensed SDA wire level |
| sclDriveLow | output | 1 | Pull SCL low when 1 |
| sdaDriveLow | output | 1 | Pull SDA low when 1 |
| lowStart | output | 1 | First cycle of a low phase |
| sdaChange | output | 1 | SDA update point |
| samplePulse | output | 1 | SDA sample point in the high phase |
| sclLevel | output | 1 | Registered SCL level for status |
| sdaLevel | output | 1 | Registered SDA level for status |

## Verification
A wrong phase counter or a bad zero-to-one mapping shows up within one clock period as a low or released run of the wrong length. A wrong midpoint register moves samplePulse to a different index inside the released run, and that is visible in the first high phase. A state machine that ignores stretching or hold shows up within a cycle of the stimulus, because the clock output toggles while it should stay put. A missing enable gate shows up as a pull-down or a strobe in the first disabled cycle.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  // Phase of the generated clock
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadLow;
    logic loadHigh;
    logic step;
  } ctl_t;

endpackage

// File: rtl/scl_gen_datapath.sv
module scl_gen_datapath
  import scl_gen_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  ctl_t             ctl,
  input  logic [REG_W-1:0] lowCount,
  input  logic             lowExt,
  input  logic [REG_W-1:0] highCount,
  input  logic             highExt,
  input  logic             inHigh,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic             sdaReqLow,
  output logic             cntAtOne,
  output logic             lowStart,
  output logic             sdaChange,
  output logic             samplePulse,
  output logic             sclLevel,
  output logic             sdaLevel,
  output logic             sdaDriveLow
);

  localparam int CNT_W = REG_W + 1;
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam int LINES = 2;

  logic [CNT_W-1:0] lowFull, highFull, effLow, effHigh, midCalc;
  logic [CNT_W-1:0] cnt, midMark;
  logic lowStartQ, sdaChgQ;
  logic [LINES-1:0] lineIn, lineQ;

  // Zero programmed counts behave as one cycle
  always_comb begin
    lowFull  = {lowExt, lowCount};
    highFull = {highExt, highCount};
    effLow   = (lowFull == '0)  ? ONE : lowFull;
    effHigh  = (highFull == '0) ? ONE : highFull;
    midCalc  = (effHigh >> 1) + {{(CNT_W-1){1'b0}}, effHigh[0]};
  end

  // Shared down counter for both phases
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      midMark <= ONE;
    end else if (ctl.loadLow) begin
      cnt <= effLow;
    end else if (ctl.loadHigh) begin
      cnt     <= effHigh;
      midMark <= midCalc;
    end else if (ctl.step) begin
      cnt <= cnt - ONE;
    end
  end

  assign cntAtOne    = (cnt == ONE);
  assign samplePulse = inHigh && (cnt == midMark);

  // Low-start and SDA-change strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowStartQ <= 1'b0;
      sdaChgQ   <= 1'b0;
    end else begin
      lowStartQ <= ctl.loadLow & enable;
      sdaChgQ   <= lowStartQ & enable;
    end
  end

  assign lowStart  = lowStartQ;
  assign sdaChange = sdaChgQ;

  // Line level status registers
  assign lineIn = {sdaIn, sclIn};
  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lineQ[g] <= 1'b1;
      else        lineQ[g] <= lineIn[g];
    end
  end

  assign sclLevel    = lineQ[0];
  assign sdaLevel    = lineQ[1];
  assign sdaDriveLow = enable & sdaReqLow;

  // R2: control never steps the counter past one
  assert_count_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.step |-> (cnt > ONE));

  // R5: SDA change follows every low start
  assert_sda_after_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lowStart && enable) |=> sdaChange);

  // R6: sample and low-start never coincide
  assert_strobe_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lowStart, samplePulse}));

endmodule

// File: rtl/scl_gen_control.sv
module scl_gen_control
  import scl_gen_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic holdLow,
  input  logic sclIn,
  input  logic cntAtOne,
  output ctl_t ctl,
  output logic inHigh,
  output logic sclDriveLow
);

  phase_e state, nextState;

  always_comb begin
    ctl       = '0;
    nextState = state;
    if (!enable) begin
      nextState = PH_IDLE;
    end else begin
      unique case (state)
        PH_IDLE: begin
          nextState   = PH_LOW;
          ctl.loadLow = 1'b1;
        end
        PH_LOW: begin
          if (cntAtOne) begin
            if (!holdLow) nextState = PH_WAIT;
          end else begin
            ctl.step = 1'b1;
          end
        end
        PH_WAIT: begin
          if (sclIn) begin
            nextState    = PH_HIGH;
            ctl.loadHigh = 1'b1;
          end
        end
        PH_HIGH: begin
          if (cntAtOne) begin
            nextState   = PH_LOW;
            ctl.loadLow = 1'b1;
          end else begin
            ctl.step = 1'b1;
          end
        end
        default: nextState = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PH_IDLE;
    else        state <= nextState;
  end

  assign sclDriveLow = (state == PH_LOW);
  assign inHigh      = (state == PH_HIGH);

  // R9: disable releases the clock on the next cycle
  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !sclDriveLow);

  // R8: hold keeps the clock low
  assert_hold_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sclDriveLow && holdLow && enable) |=> sclDriveLow);

  // R7: stretched clock keeps the generator waiting
  assert_stretch_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_WAIT && !sclIn && enable) |=> (!sclDriveLow && !inHigh));

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_gen_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [REG_W-1:0] lowCount,
  input  logic             lowExt,
  input  logic [REG_W-1:0] highCount,
  input  logic             highExt,
  input  logic             holdLow,
  input  logic             sdaReqLow,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sclDriveLow,
  output logic             sdaDriveLow,
  output logic             lowStart,
  output logic             sdaChange,
  output logic             samplePulse,
  output logic             sclLevel,
  output logic             sdaLevel
);

  ctl_t ctl;
  logic cntAtOne, inHigh;

  scl_gen_control u_control (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .holdLow     (holdLow),
    .sclIn       (sclIn),
    .cntAtOne    (cntAtOne),
    .ctl         (ctl),
    .inHigh      (inHigh),
    .sclDriveLow (sclDriveLow)
  );

  scl_gen_datapath #(.REG_W(REG_W)) u_datapath (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .ctl         (ctl),
    .lowCount    (lowCount),
    .lowExt      (lowExt),
    .highCount   (highCount),
    .highExt     (highExt),
    .inHigh      (inHigh),
    .sclIn       (sclIn),
    .sdaIn       (sdaIn),
    .sdaReqLow   (sdaReqLow),
    .cntAtOne    (cntAtOne),
    .lowStart    (lowStart),
    .sdaChange   (sdaChange),
    .samplePulse (samplePulse),
    .sclLevel    (sclLevel),
    .sdaLevel    (sdaLevel),
    .sdaDriveLow (sdaDriveLow)
  );

  // R4: every low phase opens with the low-start strobe
  assert_low_marks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclDriveLow) |-> lowStart);

endmodule

// File: tb/test_scl_timing_gen.sv
module test_scl_timing_gen;

  logic clk = 1'b0;
  logic rst_n;
  logic enable, lowExt, highExt, holdLow, sdaReqLow, sdaLine, stretch;
  logic [7:0] lowCount, highCount;
  logic sclIn;
  logic sclDriveLow, sdaDriveLow, lowStart, sdaChange, samplePulse, sclLevel, sdaLevel;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  assign sclIn = !sclDriveLow && !stretch;

  scl_timing_gen i_scl_timing_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .lowCount(lowCount), .lowExt(lowExt), .highCount(highCount), .highExt(highExt),
    .holdLow(holdLow), .sdaReqLow(sdaReqLow), .sclIn(sclIn), .sdaIn(sdaLine),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow), .lowStart(lowStart),
    .sdaChange(sdaChange), .samplePulse(samplePulse), .sclLevel(sclLevel),
    .sdaLevel(sdaLevel)
  );

  // {low count 9 bits, high count 9 bits}
  localparam int NV = 6;
  localparam logic [17:0] VEC [NV] = '{
    {9'd5,   9'd4},
    {9'd0,   9'd0},
    {9'd1,   9'd1},
    {9'd260, 9'd3},
    {9'd2,   9'd300},
    {9'd9,   9'd7}
  };

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  function automatic int eff(int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic setCounts(int l9, int h9);
    lowExt    = l9[8];
    lowCount  = l9[7:0];
    highExt   = h9[8];
    highCount = h9[7:0];
  endtask

  // Restart from disabled; returns at the negedge carrying lowStart
  task automatic startFresh(int l9, int h9);
    enable = 1'b0;
    @(negedge clk);
    setCounts(l9, h9);
    enable = 1'b1;
    @(negedge clk);
    check("R4 lowStart after enable", int'(lowStart), 1);
  endtask

  // Called at a lowStart negedge; measures one full period
  task automatic measure(output int lowLen, output int relLen,
                         output int samplePos, output int sampleCnt,
                         output int sdaOk);
    lowLen = 0; relLen = 0; samplePos = 0; sampleCnt = 0; sdaOk = 0;
    while (sclDriveLow) begin
      lowLen++;
      @(negedge clk);
      if (lowLen == 1) sdaOk = int'(sdaChange);
    end
    while (!sclDriveLow) begin
      relLen++;
      if (samplePulse) begin
        samplePos = relLen;
        sampleCnt++;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    int lowLen, relLen, samplePos, sampleCnt, sdaOk, bad, h;
    rst_n = 1'b0; enable = 1'b0; holdLow = 1'b0; sdaReqLow = 1'b0;
    sdaLine = 1'b1; stretch = 1'b0;
    setCounts(5, 4);
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset sclDriveLow", int'(sclDriveLow), 0);
    check("R1 reset strobes", int'(lowStart | sdaChange | samplePulse), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 disabled sclDriveLow", int'(sclDriveLow), 0);
    check("R1 disabled strobes", int'(lowStart | sdaChange | samplePulse), 0);

    // R10: status levels lag one cycle
    sdaLine = 1'b0;
    @(negedge clk);
    check("R10 sdaLevel low", int'(sdaLevel), 0);
    check("R10 sclLevel high", int'(sclLevel), 1);
    sdaLine = 1'b1;
    @(negedge clk);
    check("R10 sdaLevel high", int'(sdaLevel), 1);

    // R11: SDA pull-down gated by enable
    sdaReqLow = 1'b1;
    #1 check("R11 sdaDriveLow disabled", int'(sdaDriveLow), 0);
    enable = 1'b1;
    #1 check("R11 sdaDriveLow enabled", int'(sdaDriveLow), 1);
    @(negedge clk);
    sdaReqLow = 1'b0;
    enable = 1'b0;

    // Table walk: R2, R3, R5, R6
    for (int i = 0; i < NV; i++) begin
      startFresh(int'(VEC[i][17:9]), int'(VEC[i][8:0]));
      measure(lowLen, relLen, samplePos, sampleCnt, sdaOk);
      h = eff(int'(VEC[i][8:0]));
      check("R2 low length", lowLen, eff(int'(VEC[i][17:9])));
      check("R3 released length", relLen, h + 1);
      check("R6 sample position", samplePos, 1 + (h + 1 - ((h + 1) >> 1)));
      check("R6 one sample per phase", sampleCnt, 1);
      check("R5 sdaChange after lowStart", sdaOk, 1);
      check("R4 next lowStart", int'(lowStart), 1);
    end

    // R7: clock stretching
    startFresh(3, 4);
    while (sclDriveLow) @(negedge clk);
    stretch = 1'b1;
    bad = 0;
    repeat (20) begin
      @(negedge clk);
      if (sclDriveLow || samplePulse) bad++;
    end
    check("R7 no progress while stretched", bad, 0);
    stretch = 1'b0;
    relLen = 0;
    while (!sclDriveLow) begin relLen++; @(negedge clk); end
    check("R7 high count after release", relLen, 5);

    // R8: hold keeps SCL low
    startFresh(3, 4);
    holdLow = 1'b1;
    bad = 0;
    repeat (40) begin
      @(negedge clk);
      if (!sclDriveLow) bad++;
    end
    check("R8 held low", bad, 0);
    holdLow = 1'b0;
    lowLen = 0;
    while (sclDriveLow) begin lowLen++; @(negedge clk); end
    check("R8 release after hold", lowLen, 1);

    // R12: counts captured at phase start
    startFresh(5, 4);
    lowCount = 8'd9;
    measure(lowLen, relLen, samplePos, sampleCnt, sdaOk);
    check("R12 current phase unchanged", lowLen, 5);
    measure(lowLen, relLen, samplePos, sampleCnt, sdaOk);
    check("R12 next phase new count", lowLen, 9);

    // R9: disable mid high phase, then restart
    startFresh(5, 4);
    while (!samplePulse) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check("R9 released after disable", int'(sclDriveLow), 0);
    bad = 0;
    repeat (5) begin
      @(negedge clk);
      if (sclDriveLow || lowStart || sdaChange || samplePulse) bad++;
    end
    check("R9 quiet while disabled", bad, 0);
    enable = 1'b1;
    @(negedge clk);
    check("R9 restart lowStart", int'(lowStart), 1);
    check("R9 restart sclDriveLow", int'(sclDriveLow), 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule